// File: doc/BRIEF.md
# Serial ADC Frame Reader

This block is a synthesizable master for a successive-approximation ADC that sits behind a three-wire serial link. The link has a chip select output, a serial clock output and a data input. On a start request the block drives chip select low. That falling edge is the moment the converter samples its input and begins converting. After a setup spacing the block produces exactly sixteen serial clock periods from a divided system clock and shifts in the returned word, most significant bit first.

Each frame carries four leading zero bits and then the result. The block strips those framing bits and presents the unsigned straight-binary result with a one-cycle valid strobe. If any framing bit reads as one, an error flag is raised with that strobe. The `RES_BITS` parameter selects the 12-bit or 10-bit variant. In the 10-bit variant the last two frame bits are padding and are discarded.

After every frame, chip select stays high for a guaranteed quiet interval. A start request that arrives during a frame or a quiet interval is remembered and launches one frame once the block is idle again. The divider and spacing parameters are counted in system clock cycles. They are chosen so that the serial clock and the spacing stay within the converter's limits: an 18 MHz maximum serial clock, at least 10 ns from chip select low to the first serial clock fall, and at least 25 ns of quiet time.

Top module: `adc_frame_reader`

## Requirements
- R1: After reset, cs_no=1, sclk_o=0, valid_o=0, err_o=0 and busy_o=0.
- R2: A start_i pulse while idle drives cs_no low at the next clock edge, and busy_o stays high whenever cs_no is low.
- R3: While cs_no is low, sclk_o makes exactly 16 rising edges. sclk_o is low whenever cs_no is high.
- R4: During a frame every sclk_o high phase lasts DIV clock cycles, and every low phase between two rising edges also lasts DIV cycles, giving a 50% duty cycle.
- R5: The first rising edge of sclk_o comes SETUP_CYC+DIV cycles after cs_no falls, and cs_no stays low for exactly SETUP_CYC+32*DIV cycles.
- R6: sdata_i is captured on each sclk_o rising edge, MSB first, forming frame bits 15..0. With RES_BITS=12, data_o equals frame bits 11..0.
- R7: With RES_BITS=10, data_o equals frame bits 11..2, and frame bits 1..0 have no effect on data_o or err_o.
- R8: valid_o is a single-cycle pulse in the cycle after the last sclk_o falling edge of a frame. data_o changes only together with valid_o.
- R9: err_o is high with valid_o when any of frame bits 15..12 is 1. Otherwise it is low. err_o is never high without valid_o.
- R10: Between two frames, cs_no stays high for at least QUIET_CYC+1 cycles.
- R11: Start requests that arrive while busy_o is high are merged into one pending request. That request launches exactly one frame, with cs_no falling after exactly QUIET_CYC+1 high cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request one conversion frame |
| sdata_i | input | 1 | Serial data from the converter |
| cs_no | output | 1 | Chip select, active low; its falling edge sets the sampling instant |
| sclk_o | output | 1 | Serial clock, idles low |
| data_o | output | RES_BITS | Unsigned conversion result |
| valid_o | output | 1 | One-cycle strobe marking a new result |
| err_o | output | 1 | A framing bit read as one; valid with valid_o |
| busy_o | output | 1 | A frame or quiet interval is in progress |

## Verification
A start pulse while idle lowers chip select one cycle later. The first serial clock rise follows SETUP_CYC+DIV cycles after that. The result strobe appears one cycle after the sixteenth falling edge, which is SETUP_CYC+32*DIV+1 cycles after the start. The bench runs a behavioural converter model that shifts a queued frame word onto the data line at each serial clock fall. A monitor samples on the falling system clock edge and compares each strobe against the expected result popped from a scoreboard queue. Chip select low time, edge count, phase widths and quiet spacing are measured as sample counts and compared with these exact figures. Both resolutions are checked from the same serial stream.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  localparam int unsigned FRAME_BITS = 16;
  localparam int unsigned LEAD_BITS  = 4;
  localparam int unsigned NBITS_W    = $clog2(FRAME_BITS + 1);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_SHIFT,
    ST_QUIET
  } rd_state_e;
endpackage

// File: rtl/adc_sclk_div.sv
module adc_sclk_div #(
  parameter int unsigned DIV = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic sclk_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] PH_LAST = PW'(DIV - 1);

  logic [PW-1:0] ph_q;
  logic          sclk_q;
  logic          tick;

  assign tick   = en_i && (ph_q == PH_LAST);
  assign rise_o = tick && !sclk_q;
  assign fall_o = tick && sclk_q;
  assign sclk_o = sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= '0;
      sclk_q <= 1'b0;
    end else if (!en_i) begin
      ph_q   <= '0;
      sclk_q <= 1'b0;
    end else if (tick) begin
      ph_q   <= '0;
      sclk_q <= !sclk_q;
    end else begin
      ph_q   <= ph_q + 1'b1;
    end
  end
endmodule

// File: rtl/adc_frame_shift.sv
module adc_frame_shift
  import adc_rd_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clr_i,
  input  logic                  cap_i,
  input  logic                  bit_i,
  output logic [FRAME_BITS-1:0] word_o,
  output logic [NBITS_W-1:0]    nbits_o
);
  logic [FRAME_BITS-1:0] sh_q;
  logic [NBITS_W-1:0]    n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0;
      n_q  <= '0;
    end else if (clr_i) begin
      sh_q <= '0;
      n_q  <= '0;
    end else if (cap_i) begin
      sh_q <= {sh_q[FRAME_BITS-2:0], bit_i};
      n_q  <= n_q + 1'b1;
    end
  end

  assign word_o  = sh_q;
  assign nbits_o = n_q;
endmodule

// File: rtl/adc_word_unpack.sv
module adc_word_unpack
  import adc_rd_pkg::*;
#(
  parameter int unsigned RES_BITS = 12
) (
  input  logic [FRAME_BITS-1:0] word_i,
  output logic [RES_BITS-1:0]   data_o,
  output logic                  lead_err_o
);
  localparam int unsigned TOP = FRAME_BITS - LEAD_BITS - 1;

  assign lead_err_o = |word_i[FRAME_BITS-1 -: LEAD_BITS];

  generate
    if (RES_BITS == FRAME_BITS - LEAD_BITS) begin : g_full
      assign data_o = word_i[TOP:0];
    end else begin : g_padded
      // trailing padding bits below the result are dropped
      assign data_o = word_i[TOP -: RES_BITS];
    end
  endgenerate
endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
  import adc_rd_pkg::*;
#(
  parameter int unsigned RES_BITS  = 12,
  parameter int unsigned DIV       = 3,
  parameter int unsigned SETUP_CYC = 1,
  parameter int unsigned QUIET_CYC = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                sdata_i,
  output logic                cs_no,
  output logic                sclk_o,
  output logic [RES_BITS-1:0] data_o,
  output logic                valid_o,
  output logic                err_o,
  output logic                busy_o
);
  localparam int unsigned CNT_MAX = (SETUP_CYC > QUIET_CYC) ? SETUP_CYC : QUIET_CYC;
  localparam int unsigned CW      = $clog2(CNT_MAX + 1);
  localparam logic [CW-1:0] SETUP_LAST = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] QUIET_LAST = CW'(QUIET_CYC - 1);
  localparam logic [NBITS_W-1:0] NB_FULL = NBITS_W'(FRAME_BITS);

  rd_state_e st_q;
  logic [CW-1:0] cnt_q;
  logic pend_q, cs_n_q, valid_q, err_q;
  logic [RES_BITS-1:0] data_q;

  logic launch, done, rise, fall, sck_en;
  logic [FRAME_BITS-1:0] word;
  logic [NBITS_W-1:0]    nbits;
  logic [RES_BITS-1:0]   res;
  logic                  lead_err;

  assign launch = (st_q == ST_IDLE) && (start_i || pend_q);
  assign sck_en = (st_q == ST_SHIFT);
  assign done   = sck_en && fall && (nbits == NB_FULL);

  adc_sclk_div #(.DIV(DIV)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (sck_en),
    .sclk_o(sclk_o),
    .rise_o(rise),
    .fall_o(fall)
  );

  adc_frame_shift u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (launch),
    .cap_i  (sck_en && rise),
    .bit_i  (sdata_i),
    .word_o (word),
    .nbits_o(nbits)
  );

  adc_word_unpack #(.RES_BITS(RES_BITS)) u_unpack (
    .word_i    (word),
    .data_o    (res),
    .lead_err_o(lead_err)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      pend_q  <= 1'b0;
      cs_n_q  <= 1'b1;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      pend_q  <= (st_q != ST_IDLE) && (pend_q || start_i);
      unique case (st_q)
        ST_IDLE: if (launch) begin
          st_q   <= ST_SETUP;
          cnt_q  <= '0;
          cs_n_q <= 1'b0;  // sampling instant
        end
        ST_SETUP: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == SETUP_LAST) st_q <= ST_SHIFT;
        end
        ST_SHIFT: if (done) begin
          st_q    <= ST_QUIET;
          cnt_q   <= '0;
          cs_n_q  <= 1'b1;
          valid_q <= 1'b1;
          err_q   <= lead_err;
          data_q  <= res;
        end
        ST_QUIET: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == QUIET_LAST) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_no   = cs_n_q;
  assign data_o  = data_q;
  assign valid_o = valid_q;
  assign err_o   = err_q;
  assign busy_o  = (st_q != ST_IDLE);
endmodule

// File: rtl/adc_frame_reader_chk.sv
module adc_frame_reader_chk #(
  parameter int unsigned RES_BITS  = 12,
  parameter int unsigned QUIET_CYC = 3
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                cs_no,
  input logic                sclk_o,
  input logic [RES_BITS-1:0] data_o,
  input logic                valid_o,
  input logic                err_o,
  input logic                busy_o
);
  logic [7:0] hi_cnt_q;
  logic       seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_cnt_q <= '0;
      seen_q   <= 1'b0;
    end else begin
      if (!cs_no) begin
        hi_cnt_q <= '0;
        seen_q   <= 1'b1;
      end else if (hi_cnt_q != 8'hff) begin
        hi_cnt_q <= hi_cnt_q + 1'b1;
      end
    end
  end

  AST_CS_MEANS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_no |-> busy_o);  // R2
  AST_SCLK_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);  // R3
  AST_VALID_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);  // R8
  AST_DATA_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(data_o));  // R8
  AST_ERR_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> valid_o);  // R9
  AST_QUIET_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(cs_no) && seen_q) |-> (32'(hi_cnt_q) >= QUIET_CYC + 1));  // R10
endmodule

bind adc_frame_reader adc_frame_reader_chk #(
  .RES_BITS (RES_BITS),
  .QUIET_CYC(QUIET_CYC)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .cs_no  (cs_no),
  .sclk_o (sclk_o),
  .data_o (data_o),
  .valid_o(valid_o),
  .err_o  (err_o),
  .busy_o (busy_o)
);

// File: tb/adc_frame_reader_tb.sv
module adc_frame_reader_tb;
  localparam int DIV = 3, SETUP = 1, QUIET = 3;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, sdata = 1'b0;
  logic cs_n, sclk, valid, err, busy;
  logic [11:0] data;
  logic cs10, sclk10, valid10, err10, busy10;
  logic [9:0]  data10;

  int checks = 0, fails = 0, frames_done = 0;
  logic [15:0] word_q[$];
  logic [15:0] exp_q[$];

  always #5 clk = !clk;

  adc_frame_reader #(.RES_BITS(12), .DIV(DIV), .SETUP_CYC(SETUP), .QUIET_CYC(QUIET)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .sdata_i(sdata),
    .cs_no(cs_n), .sclk_o(sclk), .data_o(data), .valid_o(valid), .err_o(err), .busy_o(busy));

  adc_frame_reader #(.RES_BITS(10), .DIV(DIV), .SETUP_CYC(SETUP), .QUIET_CYC(QUIET)) u_dut10 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .sdata_i(sdata),
    .cs_no(cs10), .sclk_o(sclk10), .data_o(data10), .valid_o(valid10), .err_o(err10), .busy_o(busy10));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // converter model: MSB on chip select fall, next bit after each clock fall
  logic [15:0] cur = '0;
  int idx = 15;
  bit in_frame = 0;
  always @(negedge cs_n or negedge sclk or posedge cs_n) begin
    if (cs_n) in_frame = 0;
    else if (!in_frame) begin
      in_frame = 1;
      cur = (word_q.size() > 0) ? word_q.pop_front() : 16'h0;
      idx = 15;
    end else if (idx > 0) idx--;
    sdata <= cur[idx];
  end

  // frame timing monitor
  logic prev_cs = 1'b1, prev_sclk = 1'b0;
  int low_cnt = 0, hi_run = 0, rises = 0, run = 0, first_rise = 0;
  bit phase_bad = 0, had_frame = 0, expect_exact_gap = 0;
  always @(negedge clk) if (rst_n) begin
    if (!cs_n) begin
      low_cnt++;
      if (prev_cs) begin
        if (had_frame) begin
          chk(hi_run >= QUIET + 1, "R10 quiet spacing", hi_run, QUIET + 1);
          if (expect_exact_gap)
            chk(hi_run == QUIET + 1, "R11 pending launch gap", hi_run, QUIET + 1);
        end
        expect_exact_gap = 0;
        rises = 0; run = 0; phase_bad = 0; first_rise = 0;
      end
      if (sclk != prev_sclk) begin
        if (prev_sclk && run != DIV) phase_bad = 1;
        if (!prev_sclk && rises > 0 && run != DIV) phase_bad = 1;
        if (sclk) begin
          rises++;
          if (rises == 1) first_rise = low_cnt - 1;
        end
        run = 1;
      end else run++;
    end else begin
      if (!prev_cs) begin
        had_frame = 1; hi_run = 0;
        chk(low_cnt == SETUP + 32 * DIV, "R5 cs low length", low_cnt, SETUP + 32 * DIV);
        chk(first_rise == SETUP + DIV, "R5 first rise", first_rise, SETUP + DIV);
        chk(rises == 16, "R3 rising edges", rises, 16);
        chk(!phase_bad, "R4 phase width", phase_bad, 0);
        low_cnt = 0;
      end
      hi_run++;
      if (sclk) chk(0, "R3 sclk high while deselected", 1, 0);
    end
    prev_cs = cs_n;
    prev_sclk = sclk;
  end

  // scoreboard monitor
  always @(negedge clk) if (rst_n && (valid || valid10)) begin
    logic [15:0] w;
    bit e;
    w = (exp_q.size() > 0) ? exp_q.pop_front() : 16'hdead;
    e = |w[15:12];
    frames_done++;
    chk(valid && valid10, "R8 both strobes", {valid, valid10}, 3);
    chk(data == w[11:0], "R6 12-bit result", data, w[11:0]);
    chk(data10 == w[11:2], "R7 10-bit result", data10, w[11:2]);
    chk(err == e, "R9 error flag 12", err, e);
    chk(err10 == e, "R9 error flag 10", err10, e);
  end

  task automatic run_frame(input logic [15:0] w);
    word_q.push_back(w);
    exp_q.push_back(w);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(!cs_n && busy, "R2 launch", {cs_n, busy}, 1);
    while (busy) @(negedge clk);
  endtask

  initial begin
    logic [15:0] held_data;
    repeat (3) @(negedge clk);
    chk(cs_n && !sclk && !valid && !err && !busy, "R1 reset state",
        {cs_n, sclk, valid, err, busy}, 5'b10000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_frame(16'h0abc);
    run_frame(16'h0fff);
    run_frame(16'h0000);
    run_frame(16'h0557);   // R7: trailing bits set
    run_frame(16'h8123);   // R9
    run_frame(16'h1ffc);
    held_data = data;
    repeat (20) @(negedge clk);
    chk(data == held_data && !valid, "R8 data held", data, held_data);
    // R11: two requests during a frame merge into one follow-up
    word_q.push_back(16'h0a5a); exp_q.push_back(16'h0a5a);
    word_q.push_back(16'h0321); exp_q.push_back(16'h0321);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (30) @(negedge clk);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (10) @(negedge clk);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    expect_exact_gap = 1;
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (200) @(negedge clk);
    chk(cs_n && !busy, "R11 single pending frame", cs_n, 1);
    chk(frames_done == 8 && exp_q.size() == 0, "R11 frame count", frames_done, 8);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule